// File: doc/BRIEF.md
# Output Fault Auto-Retry Controller

This block sits between the command path of one high-side power output and its gate driver. Each clock it takes the output command, which may come from a direct pin, a serial register bit or a PWM generator, and the fault-control level. It also takes the flags raised by the analog protection circuits. From these it decides whether the gate may be driven. Hard faults park the output in a latched-off state. Overvoltage and over-current trips instead enter a timed auto-retry loop, which gives up and latches after a fixed number of counted retries.

A latch is released only by a new switch-off command, seen as a falling edge on the fault-control input. The same edge clears the sticky fault status and releases the active-low fault pin. The retry period is a parameterised count of clock cycles. A configuration bit can turn the retry loop off, so that every retry cause latches at once.

Top module: `out_retry_ctl`

## Requirements
- R1: After reset the controller is in the off state, `gate_en` is 0, `retry_cnt` is 0, `fault_status` is 0 and `fault_n` is 1.
- R2: From the off state, a clock edge with `fault_ctl`=1, `cmd_on`=1 and `ov_flag`=0 enters the on state. In the on and retry-on states `gate_en` follows `cmd_on` within the same cycle. In every other state `gate_en` is 0.
- R3: In the on or retry-on state, with `fault_ctl`=1 and `cmd_on`=1, a severe short (`sc_flag`), an on-state open load (`olon_flag`) or an over-temperature (`ot_flag`) moves the controller to latched-off. It also sets status bit 0, 1 or 2 respectively, which drives `fault_n` low.
- R4: Overvoltage in the on or retry-on state (with no R3 fault present) enters retry-off without changing `retry_cnt`. `ov_flag` sets status bit 3 in any state.
- R5: An over-current trip (`oc_flag` with `cmd_on`=1) in the on or retry-on state increments `retry_cnt` by one and enters retry-off.
- R6: Retry-off lasts at least RETRY_CYC clock edges. It moves to retry-on at the first edge after that at which `ov_flag`=0 and `cmd_on`=1.
- R7: When retry-on runs fault-free for RETRY_CYC edges, the controller returns to the on state and `retry_cnt` returns to 0.
- R8: The trip that brings `retry_cnt` to RETRY_LIMIT (16) moves the controller to latched-off and sets status bit 6.
- R9: With `retry_dis`=1, an overvoltage or over-current trip goes straight to latched-off and `retry_cnt` is left unchanged.
- R10: Latched-off holds the gate off until a falling edge of `fault_ctl`. That edge returns the controller to off, clears `retry_cnt`, and clears all status bits; a clear wins over a set in the same cycle. `fault_ctl`=0 in the on, retry-on or retry-off state returns the controller to off with `retry_cnt` cleared.
- R11: The open-load-off flag (`oloff_flag`) and the short-to-supply flag (`stv_flag`) only set status bits 4 and 5, and only while `gate_en` is 0. They never change the controller state.
- R12: `fault_n` is 0 exactly when at least one `fault_status` bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Output on command (pin, register bit or PWM) |
| fault_ctl | input | 1 | Fault-control level; a falling edge is a new switch-off |
| retry_dis | input | 1 | 1 disables the auto-retry loop |
| sc_flag | input | 1 | Severe short-circuit detected |
| olon_flag | input | 1 | Open load while on detected |
| ot_flag | input | 1 | Over-temperature detected |
| ov_flag | input | 1 | Supply overvoltage detected |
| oc_flag | input | 1 | Over-current trip (retry cause) |
| oloff_flag | input | 1 | Open load while off detected |
| stv_flag | input | 1 | Output shorted to supply detected |
| gate_en | output | 1 | Gate drive enable |
| retry_cnt | output | CNT_W (5) | Counted retries since last clean run |
| fault_status | output | 7 | Sticky status: 0 sc, 1 olon, 2 ot, 3 ov, 4 oloff, 5 stv, 6 retries exhausted |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Directed sequences drive single over-current trips, held and released overvoltage, a full run of sixteen trips, each latching fault, and the disabled-retry mode. Together they separate counted from uncounted retries, a waiting retry-off from a timed one, and a latch from a retry. Off-state flags are raised with the command low and the state is then probed by raising the command, which shows whether any transition took place. Long seeded random runs with sparse fault pulses and occasional fault-control toggles exercise coincident causes, which brings out priority errors and clear-versus-set ordering. They are compared against a bench reference every cycle.

// File: rtl/orc_pkg.sv
package orc_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_ON      = 3'd1,
        ST_LATCH   = 3'd2,
        ST_RTY_OFF = 3'd3,
        ST_RTY_ON  = 3'd4
    } orc_state_e;

    localparam int STAT_W = 7;

    // bit 6 .. bit 0
    typedef struct packed {
        logic exh;
        logic stv;
        logic oloff;
        logic ov;
        logic ot;
        logic olon;
        logic sc;
    } orc_status_t;

endpackage

// File: rtl/orc_retry_timer.sv
module orc_retry_timer #(
    parameter int RETRY_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);
    localparam int TW = (RETRY_CYC > 2) ? $clog2(RETRY_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(RETRY_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    assign done = (r_q.tmr == LAST);

    always_comb begin
        r_d = r_q;
        if (!run || restart) begin
            r_d.tmr = '0;
        end else if (!done) begin
            r_d.tmr = r_q.tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/orc_status_reg.sv
module orc_status_reg
    import orc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  orc_status_t set,
    output orc_status_t status
);
    typedef struct packed {
        orc_status_t st;
    } stat_regs_t;

    stat_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) r_d.st = '0;
        else     r_d.st = r_q.st | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status = r_q.st;
endmodule

// File: rtl/orc_fsm.sv
module orc_fsm
    import orc_pkg::*;
#(
    parameter int RETRY_LIMIT = 16,
    parameter int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_on,
    input  logic             fault_ctl,
    input  logic             clr,
    input  logic             retry_dis,
    input  logic             hard_flt,
    input  logic             ov_flag,
    input  logic             oc_flag,
    input  logic             tmr_done,
    output orc_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             restart,
    output logic             exh_set
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RETRY_LIMIT);

    typedef struct packed {
        orc_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t        r_q, r_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             fault_hit;

    always_comb begin
        r_d       = r_q;
        exh_set   = 1'b0;
        cnt_inc   = r_q.cnt + 1'b1;
        fault_hit = cmd_on && hard_flt;
        unique case (r_q.st)
            ST_OFF: begin
                if (fault_ctl && cmd_on && !ov_flag) r_d.st = ST_ON;
            end
            ST_ON, ST_RTY_ON: begin
                if (!fault_ctl) begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end else if (fault_hit) begin
                    r_d.st = ST_LATCH;
                end else if (ov_flag) begin
                    r_d.st = retry_dis ? ST_LATCH : ST_RTY_OFF;
                end else if (cmd_on && oc_flag) begin
                    if (retry_dis) begin
                        r_d.st = ST_LATCH;
                    end else begin
                        r_d.cnt = cnt_inc;
                        if (cnt_inc == LIMIT) begin
                            r_d.st  = ST_LATCH;
                            exh_set = 1'b1;
                        end else begin
                            r_d.st = ST_RTY_OFF;
                        end
                    end
                end else if (r_q.st == ST_RTY_ON && tmr_done) begin
                    r_d.st  = ST_ON;
                    r_d.cnt = '0;
                end
            end
            ST_RTY_OFF: begin
                if (!fault_ctl) begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end else if (tmr_done && !ov_flag && cmd_on) begin
                    r_d.st = ST_RTY_ON;
                end
            end
            ST_LATCH: begin
                if (clr) begin
                    r_d.st  = ST_OFF;
                    r_d.cnt = '0;
                end
            end
            default: begin
                r_d.st  = ST_OFF;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_OFF;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state   = r_q.st;
    assign cnt     = r_q.cnt;
    assign restart = (r_d.st != r_q.st);
endmodule

// File: rtl/out_retry_ctl.sv
module out_retry_ctl
    import orc_pkg::*;
#(
    parameter int RETRY_CYC   = 32,
    parameter int RETRY_LIMIT = 16,
    parameter int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_on,
    input  logic                     fault_ctl,
    input  logic                     retry_dis,
    input  logic                     sc_flag,
    input  logic                     olon_flag,
    input  logic                     ot_flag,
    input  logic                     ov_flag,
    input  logic                     oc_flag,
    input  logic                     oloff_flag,
    input  logic                     stv_flag,
    output logic                     gate_en,
    output logic [CNT_W-1:0]         retry_cnt,
    output logic [STAT_W-1:0]        fault_status,
    output logic                     fault_n
);
    typedef struct packed {
        logic fc;
    } top_regs_t;

    top_regs_t   r_q, r_d;
    orc_state_e  st_w;
    orc_status_t set_w, stat_w;
    logic        clr_w, on_w, restart_w, done_w, exh_w, run_w, live_w;

    always_comb begin
        r_d    = r_q;
        r_d.fc = fault_ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clr_w  = r_q.fc && !fault_ctl;
    assign on_w   = (st_w == ST_ON) || (st_w == ST_RTY_ON);
    assign run_w  = (st_w == ST_RTY_OFF) || (st_w == ST_RTY_ON);
    assign live_w = on_w && fault_ctl && cmd_on;

    assign gate_en = on_w && cmd_on;

    always_comb begin
        set_w       = '0;
        set_w.sc    = live_w && sc_flag;
        set_w.olon  = live_w && olon_flag;
        set_w.ot    = live_w && ot_flag;
        set_w.ov    = ov_flag;
        set_w.oloff = oloff_flag && !gate_en;
        set_w.stv   = stv_flag && !gate_en;
        set_w.exh   = exh_w;
    end

    orc_fsm #(
        .RETRY_LIMIT (RETRY_LIMIT),
        .CNT_W       (CNT_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_on    (cmd_on),
        .fault_ctl (fault_ctl),
        .clr       (clr_w),
        .retry_dis (retry_dis),
        .hard_flt  (sc_flag || olon_flag || ot_flag),
        .ov_flag   (ov_flag),
        .oc_flag   (oc_flag),
        .tmr_done  (done_w),
        .state     (st_w),
        .cnt       (retry_cnt),
        .restart   (restart_w),
        .exh_set   (exh_w)
    );

    orc_retry_timer #(
        .RETRY_CYC (RETRY_CYC)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (restart_w),
        .done    (done_w)
    );

    orc_status_reg stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_w),
        .set    (set_w),
        .status (stat_w)
    );

    assign fault_status = stat_w;
    assign fault_n      = (stat_w == '0);
endmodule

// File: rtl/orc_chk.sv
module orc_chk
    import orc_pkg::*;
#(
    parameter int RETRY_LIMIT = 16,
    parameter int CNT_W       = $clog2(RETRY_LIMIT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_on,
    input logic              fault_ctl,
    input logic              retry_dis,
    input logic              sc_flag,
    input logic              olon_flag,
    input logic              ot_flag,
    input logic              ov_flag,
    input logic              gate_en,
    input logic [CNT_W-1:0]  retry_cnt,
    input logic [STAT_W-1:0] fault_status,
    input logic              fault_n,
    input orc_state_e        st
);
    logic on_st;
    assign on_st = (st == ST_ON) || (st == ST_RTY_ON);

    // R2
    gate_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> cmd_on);

    // R3
    hard_fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_st && fault_ctl && cmd_on && (sc_flag || olon_flag || ot_flag))
        |=> (st == ST_LATCH && !fault_n));

    // R4
    ov_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_st && fault_ctl && !(cmd_on && (sc_flag || olon_flag || ot_flag))
         && ov_flag && !retry_dis)
        |=> (st == ST_RTY_OFF && $stable(retry_cnt)));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != $past(retry_cnt))
        |-> (retry_cnt == $past(retry_cnt) + 1'b1 || retry_cnt == '0));

    // R8
    limit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt == CNT_W'(RETRY_LIMIT)) |-> (st == ST_LATCH && fault_status[6]));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_ctl) |=> (fault_status == '0 && fault_n));

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !(fault_ctl && cmd_on)) |=> (st == ST_OFF));
endmodule

bind out_retry_ctl orc_chk #(
    .RETRY_LIMIT (RETRY_LIMIT),
    .CNT_W       (CNT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_on       (cmd_on),
    .fault_ctl    (fault_ctl),
    .retry_dis    (retry_dis),
    .sc_flag      (sc_flag),
    .olon_flag    (olon_flag),
    .ot_flag      (ot_flag),
    .ov_flag      (ov_flag),
    .gate_en      (gate_en),
    .retry_cnt    (retry_cnt),
    .fault_status (fault_status),
    .fault_n      (fault_n),
    .st           (st_w)
);

// File: tb/out_retry_ctl_tb_top.sv
module out_retry_ctl_tb_top;
    localparam int P   = 8;
    localparam int LIM = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_on = 0, fault_ctl = 0, retry_dis = 0;
    logic sc_flag = 0, olon_flag = 0, ot_flag = 0, ov_flag = 0;
    logic oc_flag = 0, oloff_flag = 0, stv_flag = 0;
    logic       gate_en, fault_n;
    logic [4:0] retry_cnt;
    logic [6:0] fault_status;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    out_retry_ctl #(.RETRY_CYC(P), .RETRY_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .fault_ctl(fault_ctl),
        .retry_dis(retry_dis), .sc_flag(sc_flag), .olon_flag(olon_flag),
        .ot_flag(ot_flag), .ov_flag(ov_flag), .oc_flag(oc_flag),
        .oloff_flag(oloff_flag), .stv_flag(stv_flag), .gate_en(gate_en),
        .retry_cnt(retry_cnt), .fault_status(fault_status), .fault_n(fault_n)
    );

    // reference: 0 off, 1 on, 2 latched, 3 retry-off, 4 retry-on
    int         m_st = 0;
    int         m_tmr = 0;
    logic [4:0] m_cnt = 0;
    logic [6:0] m_stat = 0;
    logic       m_fcq = 0;

    function automatic logic m_on(int s);
        return (s == 1) || (s == 4);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_cnt = 0; m_stat = 0; m_fcq = 0;
        end else begin
            int ns; logic [4:0] nc; logic exh, clr, gate, live, done, hard;
            logic [6:0] set;
            ns = m_st; nc = m_cnt; exh = 0;
            gate = m_on(m_st) && cmd_on;
            live = m_on(m_st) && fault_ctl && cmd_on;
            clr  = m_fcq && !fault_ctl;
            done = (m_tmr == P - 1);
            hard = sc_flag || olon_flag || ot_flag;
            case (m_st)
                0: if (fault_ctl && cmd_on && !ov_flag) ns = 1;
                1, 4: begin
                    if (!fault_ctl) begin ns = 0; nc = 0; end
                    else if (cmd_on && hard) ns = 2;
                    else if (ov_flag) ns = retry_dis ? 2 : 3;
                    else if (cmd_on && oc_flag) begin
                        if (retry_dis) ns = 2;
                        else begin
                            nc = m_cnt + 1;
                            if (nc == LIM) begin ns = 2; exh = 1; end
                            else ns = 3;
                        end
                    end else if (m_st == 4 && done) begin ns = 1; nc = 0; end
                end
                3: begin
                    if (!fault_ctl) begin ns = 0; nc = 0; end
                    else if (done && !ov_flag && cmd_on) ns = 4;
                end
                default: if (clr) begin ns = 0; nc = 0; end
            endcase
            set = {exh, stv_flag && !gate, oloff_flag && !gate, ov_flag,
                   live && ot_flag, live && olon_flag, live && sc_flag};
            m_stat = clr ? 7'd0 : (m_stat | set);
            if (ns != m_st || !(m_st == 3 || m_st == 4)) m_tmr = 0;
            else if (!done) m_tmr = m_tmr + 1;
            m_st = ns; m_cnt = nc; m_fcq = fault_ctl;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_cmp();
        chk("R2 gate_en vs reference", 32'(gate_en), 32'(m_on(m_st) && cmd_on));
        chk("R5 retry_cnt vs reference", 32'(retry_cnt), 32'(m_cnt));
        chk("R4 fault_status vs reference", 32'(fault_status), 32'(m_stat));
        chk("R12 fault_n vs reference", 32'(fault_n), 32'(m_stat == 0));
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_cmp();
        end
    endtask

    task automatic clear_and_on();
        fault_ctl = 0; tick();
        fault_ctl = 1; tick();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 gate_en", 32'(gate_en), 0);
        chk("R1 retry_cnt", 32'(retry_cnt), 0);
        chk("R1 fault_status", 32'(fault_status), 0);
        chk("R1 fault_n", 32'(fault_n), 1);

        // R2 turn on, gate follows command
        fault_ctl = 1; cmd_on = 1; tick();
        chk("R2 gate on", 32'(gate_en), 1);
        cmd_on = 0; #1;
        chk("R2 gate follows cmd low", 32'(gate_en), 0);
        cmd_on = 1; #1;

        // R5 single trip
        oc_flag = 1; tick(); oc_flag = 0;
        chk("R5 count after trip", 32'(retry_cnt), 1);
        chk("R5 gate off in retry", 32'(gate_en), 0);
        // R6 retry-off duration
        n = 0;
        do begin tick(); n++; end while (!gate_en && n < 100);
        chk("R6 retry-off edges", 32'(n), P);
        // R7 fault-free run clears counter
        tick(P - 1);
        chk("R7 count kept before period", 32'(retry_cnt), 1);
        tick();
        chk("R7 count cleared after period", 32'(retry_cnt), 0);

        // R4 overvoltage, uncounted, waits while held
        ov_flag = 1; tick();
        chk("R4 gate off", 32'(gate_en), 0);
        chk("R4 count unchanged", 32'(retry_cnt), 0);
        chk("R4 ov status", 32'(fault_status[3]), 1);
        tick(2 * P);
        chk("R6 held while ov", 32'(gate_en), 0);
        ov_flag = 0; tick();
        chk("R6 resumes when ov clears", 32'(gate_en), 1);
        fault_ctl = 0; tick();
        chk("R10 status cleared", 32'(fault_status), 0);
        chk("R12 fault_n released", 32'(fault_n), 1);
        fault_ctl = 1; tick();

        // R8 retries exhausted
        for (int k = 1; k <= LIM; k++) begin
            oc_flag = 1; tick(); oc_flag = 0;
            if (k < LIM) begin
                chk("R5 count step", 32'(retry_cnt), 32'(k));
                tick(P);
            end
        end
        chk("R8 count at limit", 32'(retry_cnt), LIM);
        chk("R8 exhausted bit", 32'(fault_status[6]), 1);
        chk("R8 gate off", 32'(gate_en), 0);
        tick(3 * P);
        chk("R10 latch holds", 32'(gate_en), 0);
        fault_ctl = 0; tick();
        chk("R10 count cleared", 32'(retry_cnt), 0);
        chk("R10 status cleared on edge", 32'(fault_status), 0);
        fault_ctl = 1; tick();
        chk("R10 on after clear", 32'(gate_en), 1);

        // R3 severe short latches
        sc_flag = 1; tick(); sc_flag = 0;
        chk("R3 gate off", 32'(gate_en), 0);
        chk("R3 sc bit", 32'(fault_status), 32'h01);
        chk("R12 fault_n low", 32'(fault_n), 0);
        tick(2 * P);
        chk("R3 stays latched", 32'(gate_en), 0);
        clear_and_on();

        // R9 retry disabled
        retry_dis = 1;
        oc_flag = 1; tick(); oc_flag = 0;
        chk("R9 count unchanged", 32'(retry_cnt), 0);
        chk("R9 no status", 32'(fault_n), 1);
        tick(2 * P);
        chk("R9 latched not retried", 32'(gate_en), 0);
        clear_and_on();
        retry_dis = 0;

        // R11 off-state flags only set status
        cmd_on = 0;
        oloff_flag = 1; tick(); oloff_flag = 0;
        chk("R11 oloff bit", 32'(fault_status[4]), 1);
        stv_flag = 1; tick(); stv_flag = 0;
        chk("R11 stv bit", 32'(fault_status[5]), 1);
        cmd_on = 1; #1;
        chk("R11 state kept (gate on)", 32'(gate_en), 1);
        clear_and_on();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(39) == 0) fault_ctl = ~fault_ctl;
            cmd_on     = ($urandom_range(7) != 0);
            sc_flag    = ($urandom_range(59) == 0);
            olon_flag  = ($urandom_range(59) == 0);
            ot_flag    = ($urandom_range(59) == 0);
            ov_flag    = ($urandom_range(39) == 0);
            oc_flag    = ($urandom_range(9) == 0);
            oloff_flag = ($urandom_range(29) == 0);
            stv_flag   = ($urandom_range(29) == 0);
            if ($urandom_range(199) == 0) retry_dis = ~retry_dis;
            tick();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule